// File: doc/BRIEF.md
# Video-Memory Block Copy Engine

This engine copies bytes from a 16-bit system address space into an 8 KiB video-memory window. Software loads a source pointer, a destination pointer and a length/status byte. It then starts a transfer in one of two ways. A general request moves the whole programmed amount in a single burst. In blanking mode, each pulse on the blanking request input moves one 16-byte block. Blanking mode suits a display controller that sends one pulse per line interval.

The engine reads sources through a synchronous memory port with one cycle of read latency. It writes each byte to the video port one pipeline stage later. Sources that cannot be read (the video window itself and the region at the very top of the map) are never fetched, and 0xFF is stored in their place. The source and destination pointers survive from one chunk to the next. A chunk that would run past the top of the address space is cut short, and this sets the status flag. The busy output covers a chunk from acceptance to its last write. When a chunk ends, the engine pulses `done`, reports the bus-cycle cost of the chunk, and rewrites the length/status byte.

Top module: `vblk_dma`

## Requirements
- R1: A general request (`gen_go` while blanking is not armed) moves (len[6:0] + 1) × 16 bytes in one chunk. Byte k of the chunk takes source address (src + k) mod 65536.
- R2: Writing the length register with bit 8 of the data set arms blanking mode. While armed, each `blank_req` pulse moves exactly 16 bytes and `gen_go` is ignored. While disarmed, `blank_req` is ignored.
- R3: Byte k of a chunk is written at address 0x8000 | ((dst + k) & 0x1FFF).
- R4: A source address in 0x8000..0x9FFF or above 0xFDFF is not read (`rd_en` stays low for that byte), and 0xFF is written instead. Every other source is read, and the value read is written.
- R5: If dst + chunk length ≥ 0x10000, the chunk is cut to 0x10000 − dst bytes and bit 7 of the length register is set at the end of the chunk.
- R6: If `disp_en` is low when a chunk is accepted, the remaining length after that chunk is zero, so the length register reads 0xFF afterwards.
- R7: At the end of a chunk, the length register becomes ((remaining bytes / 16) − 1) mod 256, ORed with bit 7 if bit 7 was already set or the chunk overflowed. Remaining bytes are the programmed bytes minus the bytes moved.
- R8: `cost` is updated with the `done` pulse and equals bytes × 2 + 4, or bytes × 4 + 4 when `dbl_speed` was high at acceptance.
- R9: If the length register ends a chunk with bit 7 set, blanking mode is disarmed (`blank_on` low).
- R10: The source and destination pointers are kept between chunks, so the next chunk continues at the following byte without reprogramming.
- R11: `busy` is high from the cycle after acceptance through the cycle of the last write, and `done` pulses in the cycle `busy` falls. Requests and register writes made while busy are ignored.
- R12: After reset, `busy`, `done`, `rd_en`, `vw_en`, `blank_on` and the length register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 length |
| cfg_wdata | input | 16 | Write data; for length, bits 7:0 are the value and bit 8 arms blanking mode |
| gen_go | input | 1 | General transfer request pulse |
| blank_req | input | 1 | Blanking-mode block request pulse |
| disp_en | input | 1 | Display enabled, sampled at acceptance |
| dbl_speed | input | 1 | Double-speed timing, sampled at acceptance |
| rd_en | output | 1 | Source memory read enable |
| rd_addr | output | 16 | Source memory address |
| rd_data | input | 8 | Source data, valid one cycle after `rd_en` |
| vw_en | output | 1 | Video-memory write enable |
| vw_addr | output | 16 | Video-memory write address |
| vw_data | output | 8 | Video-memory write data |
| busy | output | 1 | Chunk in progress |
| done | output | 1 | One-cycle pulse at the end of a chunk |
| cost | output | 15 | Bus-cycle cost of the last chunk |
| len_out | output | 8 | Length/status register |
| blank_on | output | 1 | Blanking mode armed |

## Verification
The bench builds the engine with its default parameters: 16-byte blocks, a 7-bit block count and a 13-bit video window. These values make the whole 1-to-128-block length range reachable, together with both ends of the 16-bit address space. Within a few thousand cycles the runs cover address wrap at 0xFFFF, window folding across 0x9FFF, entry into and exit from both unreadable source regions, and overflow cuts that land exactly on or short of the top. Every written byte is compared against an arithmetic model of its address and data. Each chunk's cost, length/status byte and arming state are predicted from the same model.

// File: rtl/vblk_dma_pkg.sv
package vblk_dma_pkg;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] VID_LO   = 16'h8000;
  localparam logic [ADDR_W-1:0] VID_HI   = 16'h9FFF;
  localparam logic [ADDR_W-1:0] TOP_LAST = 16'hFDFF;

  typedef enum logic [1:0] {
    SEL_SRC = 2'd0,
    SEL_DST = 2'd1,
    SEL_LEN = 2'd2
  } cfg_sel_e;

  // True when a source byte may be fetched from memory.
  function automatic logic src_ok(input logic [ADDR_W-1:0] a);
    return !((a >= VID_LO && a <= VID_HI) || a > TOP_LAST);
  endfunction
endpackage

// File: rtl/vblk_dma_plan.sv
module vblk_dma_plan
  import vblk_dma_pkg::*;
#(
  parameter int BLK_LG   = 4,
  parameter int LEN_BITS = 7,
  parameter int LW       = LEN_BITS + 1,
  parameter int BYTES_W  = LEN_BITS + BLK_LG + 1,
  parameter int COST_W   = BYTES_W + 3
) (
  input  logic [LEN_BITS-1:0] len_field,
  input  logic [ADDR_W-1:0]   dst,
  input  logic                blank,
  input  logic                disp_en,
  input  logic                dbl,
  input  logic                old_flag,
  output logic [BYTES_W-1:0]  chunk_bytes,
  output logic [LW-1:0]       next_len,
  output logic                ovf,
  output logic [COST_W-1:0]   cost
);
  logic [BYTES_W-1:0] prog_bytes;
  logic [BYTES_W-1:0] want;
  logic [ADDR_W:0]    room;
  logic [BYTES_W-1:0] rem;
  logic [LW-1:0]      blocks_m1;

  always_comb begin
    prog_bytes  = (BYTES_W'(len_field) + BYTES_W'(1)) << BLK_LG;
    want        = blank ? BYTES_W'(1 << BLK_LG) : prog_bytes;
    room        = (ADDR_W+1)'(1 << ADDR_W) - {1'b0, dst};
    ovf         = ((ADDR_W+1)'(want) >= room);
    chunk_bytes = ovf ? BYTES_W'(room) : want;
    rem         = disp_en ? (prog_bytes - chunk_bytes) : '0;
    blocks_m1   = LW'(rem >> BLK_LG) - LW'(1);
    next_len    = {blocks_m1[LW-1] | old_flag | ovf, blocks_m1[LW-2:0]};
    cost        = (COST_W'(chunk_bytes) << (dbl ? 2 : 1)) + COST_W'(4);
  end
endmodule

// File: rtl/vblk_dma_mover.sv
module vblk_dma_mover
  import vblk_dma_pkg::*;
#(
  parameter int              DW       = 8,
  parameter int              WIN_LG   = 13,
  parameter logic [15:0]     WIN_BASE = 16'h8000,
  parameter int              BYTES_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_src,
  input  logic                ld_dst,
  input  logic [ADDR_W-1:0]   ld_val,
  input  logic                start,
  input  logic [BYTES_W-1:0]  start_bytes,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [DW-1:0]       rd_data,
  output logic                vw_en,
  output logic [ADDR_W-1:0]   vw_addr,
  output logic [DW-1:0]       vw_data,
  output logic [ADDR_W-1:0]   dst_cur,
  output logic                busy,
  output logic                chunk_end
);
  logic [ADDR_W-1:0]  src_q, dst_q;
  logic               run_q;
  logic [BYTES_W-1:0] left_q;
  logic               p_valid_q, p_inv_q, p_last_q;
  logic [WIN_LG-1:0]  p_off_q;
  logic               vw_en_q, vw_last_q;
  logic [ADDR_W-1:0]  vw_addr_q;
  logic [DW-1:0]      vw_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      run_q     <= 1'b0;
      left_q    <= '0;
      p_valid_q <= 1'b0;
      p_inv_q   <= 1'b0;
      p_last_q  <= 1'b0;
      p_off_q   <= '0;
      vw_en_q   <= 1'b0;
      vw_last_q <= 1'b0;
      vw_addr_q <= '0;
      vw_data_q <= '0;
    end else begin
      if (ld_src) src_q <= ld_val;
      if (ld_dst) dst_q <= ld_val;
      if (start) begin
        run_q  <= 1'b1;
        left_q <= start_bytes;
      end else if (run_q) begin
        src_q  <= src_q + 1'b1;
        dst_q  <= dst_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == BYTES_W'(1)) run_q <= 1'b0;
      end
      // stage 1: read in flight
      p_valid_q <= run_q;
      p_inv_q   <= !src_ok(src_q);
      p_off_q   <= dst_q[WIN_LG-1:0];
      p_last_q  <= (left_q == BYTES_W'(1));
      // stage 2: registered video write
      vw_en_q   <= p_valid_q;
      vw_last_q <= p_valid_q & p_last_q;
      vw_addr_q <= WIN_BASE | ADDR_W'(p_off_q);
      vw_data_q <= p_inv_q ? {DW{1'b1}} : rd_data;
    end
  end

  assign rd_en     = run_q & src_ok(src_q);
  assign rd_addr   = src_q;
  assign vw_en     = vw_en_q;
  assign vw_addr   = vw_addr_q;
  assign vw_data   = vw_data_q;
  assign dst_cur   = dst_q;
  assign busy      = run_q | p_valid_q | vw_en_q;
  assign chunk_end = vw_en_q & vw_last_q;

  assert_window_R3: assert property (@(posedge clk) disable iff (rst)
    vw_en |-> (vw_addr[ADDR_W-1:WIN_LG] == WIN_BASE[ADDR_W-1:WIN_LG]))
    else $error("video write outside window");

  assert_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (p_valid_q && p_inv_q) |=> (vw_en && vw_data == {DW{1'b1}}))
    else $error("unreadable source not replaced by all-ones");
endmodule

// File: rtl/vblk_dma.sv
module vblk_dma
  import vblk_dma_pkg::*;
#(
  parameter int          BLK_LG   = 4,
  parameter int          LEN_BITS = 7,
  parameter int          WIN_LG   = 13,
  parameter logic [15:0] WIN_BASE = 16'h8000,
  parameter int          DW       = 8,
  parameter int          LW       = LEN_BITS + 1,
  parameter int          BYTES_W  = LEN_BITS + BLK_LG + 1,
  parameter int          COST_W   = BYTES_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              gen_go,
  input  logic              blank_req,
  input  logic              disp_en,
  input  logic              dbl_speed,
  output logic              rd_en,
  output logic [15:0]       rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic              vw_en,
  output logic [15:0]       vw_addr,
  output logic [DW-1:0]     vw_data,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic [LW-1:0]     len_out,
  output logic              blank_on
);
  logic [LW-1:0]      len_q, pend_len_q;
  logic               blank_q, done_q, pend_ovf_q;
  logic [COST_W-1:0]  pend_cost_q, cost_q;
  logic               busy_w, chunk_end, accept, cfg_ok;
  logic [ADDR_W-1:0]  dst_cur;
  logic [BYTES_W-1:0] chunk_bytes;
  logic [LW-1:0]      next_len;
  logic               ovf_c;
  logic [COST_W-1:0]  cost_c;
  cfg_sel_e           sel;

  assign sel    = cfg_sel_e'(cfg_sel);
  assign cfg_ok = cfg_we & ~busy_w;
  assign accept = ~busy_w & (blank_q ? blank_req : gen_go);

  vblk_dma_plan #(
    .BLK_LG(BLK_LG), .LEN_BITS(LEN_BITS), .LW(LW),
    .BYTES_W(BYTES_W), .COST_W(COST_W)
  ) u_plan (
    .len_field  (len_q[LEN_BITS-1:0]),
    .dst        (dst_cur),
    .blank      (blank_q),
    .disp_en    (disp_en),
    .dbl        (dbl_speed),
    .old_flag   (len_q[LW-1]),
    .chunk_bytes(chunk_bytes),
    .next_len   (next_len),
    .ovf        (ovf_c),
    .cost       (cost_c)
  );

  vblk_dma_mover #(
    .DW(DW), .WIN_LG(WIN_LG), .WIN_BASE(WIN_BASE), .BYTES_W(BYTES_W)
  ) u_mover (
    .clk        (clk),
    .rst        (rst),
    .ld_src     (cfg_ok && sel == SEL_SRC),
    .ld_dst     (cfg_ok && sel == SEL_DST),
    .ld_val     (cfg_wdata),
    .start      (accept),
    .start_bytes(chunk_bytes),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .vw_en      (vw_en),
    .vw_addr    (vw_addr),
    .vw_data    (vw_data),
    .dst_cur    (dst_cur),
    .busy       (busy_w),
    .chunk_end  (chunk_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q       <= '0;
      blank_q     <= 1'b0;
      pend_len_q  <= '0;
      pend_ovf_q  <= 1'b0;
      pend_cost_q <= '0;
      cost_q      <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_ok && sel == SEL_LEN) begin
        len_q   <= cfg_wdata[LW-1:0];
        blank_q <= cfg_wdata[LW];
      end
      if (accept) begin
        pend_len_q  <= next_len;
        pend_ovf_q  <= ovf_c;
        pend_cost_q <= cost_c;
      end
      if (chunk_end) begin
        len_q  <= pend_len_q;
        cost_q <= pend_cost_q;
        done_q <= 1'b1;
        if (pend_len_q[LW-1]) blank_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_w;
  assign done     = done_q;
  assign cost     = cost_q;
  assign len_out  = len_q;
  assign blank_on = blank_q;

  assert_busy_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done)
    else $error("busy fell without a done pulse");

  assert_blank_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (done && len_out[LW-1]) |-> !blank_on)
    else $error("blanking still armed with flag set");

  assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (chunk_end && pend_ovf_q) |=> len_out[LW-1])
    else $error("overflowing chunk left flag clear");

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done)
    else $error("done held for more than one cycle");
endmodule

// File: tb/vblk_dma_tb.sv
`timescale 1ns/1ps
module vblk_dma_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        gen_go = 1'b0, blank_req = 1'b0;
  logic        disp_en = 1'b1, dbl_speed = 1'b0;
  logic        rd_en, vw_en, busy, done, blank_on;
  logic [15:0] rd_addr, vw_addr;
  logic [7:0]  rd_data = 8'd0, vw_data, len_out;
  logic [14:0] cost;

  int n_chk = 0, n_bad = 0;
  int m_src = 0, m_dst = 0, m_len = 0;
  bit m_blank = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vblk_dma u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .gen_go(gen_go), .blank_req(blank_req), .disp_en(disp_en), .dbl_speed(dbl_speed),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .vw_en(vw_en), .vw_addr(vw_addr), .vw_data(vw_data),
    .busy(busy), .done(done), .cost(cost), .len_out(len_out), .blank_on(blank_on)
  );

  function automatic bit readable(int a);
    return !((a >= 'h8000 && a <= 'h9FFF) || a > 'hFDFF);
  endfunction

  function automatic logic [7:0] mdat(int a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mdat(int'(rd_addr));

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgw(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(int src, int dst, int len, bit arm);
    cfgw(0, src); cfgw(1, dst); cfgw(2, len | (int'(arm) << 8));
    m_src = src; m_dst = dst; m_len = len; m_blank = arm;
  endtask

  // One chunk, started by the request that matches the armed state.
  task automatic chunk(bit disp, bit dbl, bit poke, string tag);
    int pbytes, want, room, n, rem, nl, ecost, wr, rd, erd, cyc, a, ea;
    bit ovf, useb;
    useb   = m_blank;
    pbytes = ((m_len & 'h7F) + 1) * 16;
    want   = useb ? 16 : pbytes;
    room   = 'h10000 - m_dst;
    ovf    = (want >= room);
    n      = ovf ? room : want;
    rem    = disp ? pbytes - n : 0;
    nl     = (((rem / 16) - 1) & 'hFF) | (((m_len >> 7) & 1) | int'(ovf)) << 7;
    ecost  = n * (dbl ? 4 : 2) + 4;
    @(negedge clk);
    disp_en = disp; dbl_speed = dbl;
    if (useb) blank_req = 1'b1; else gen_go = 1'b1;
    @(negedge clk);
    gen_go = 1'b0; blank_req = 1'b0;
    check(busy == 1'b1, {"R11 busy after accept ", tag}, busy, 1);
    wr = 0; rd = 0; erd = 0; cyc = 0;
    for (int k = 0; k < n; k++) if (readable((m_src + k) & 'hFFFF)) erd++;
    while (busy && cyc < 5000) begin
      if (rd_en) rd++;
      if (vw_en) begin
        a  = (m_src + wr) & 'hFFFF;
        ea = 'h8000 | ((m_dst + wr) & 'h1FFF);
        check(int'(vw_addr) == ea, {"R3 address ", tag}, vw_addr, ea);
        if (readable(a))
          check(vw_data == mdat(a), {"R1 data ", tag}, vw_data, mdat(a));
        else
          check(vw_data == 8'hFF, {"R4 fill ", tag}, vw_data, 'hFF);
        wr++;
      end
      gen_go = poke && (cyc == 3); blank_req = poke && (cyc == 3);
      cyc++;
      @(negedge clk);
    end
    gen_go = 1'b0; blank_req = 1'b0;
    check(wr == n, {"R1 R5 byte count ", tag}, wr, n);
    check(rd == erd, {"R4 reads issued ", tag}, rd, erd);
    check(done == 1'b1, {"R11 done pulse ", tag}, done, 1);
    check(int'(cost) == ecost, {"R8 cost ", tag}, cost, ecost);
    check(int'(len_out) == nl, {"R7 length status ", tag}, len_out, nl);
    m_src = (m_src + n) & 'hFFFF;
    m_dst = (m_dst + n) & 'hFFFF;
    m_len = nl;
    if (nl[7]) m_blank = 0;
    check(blank_on == m_blank, {"R9 arming ", tag}, blank_on, m_blank);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, {"R11 idle after chunk ", tag}, busy, 0);
  endtask

  task automatic expect_ignored(bit use_gen, string req);
    @(negedge clk);
    if (use_gen) gen_go = 1'b1; else blank_req = 1'b1;
    @(negedge clk);
    gen_go = 1'b0; blank_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(!busy && !vw_en && !rd_en, req, busy, 0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!busy && !done && !rd_en && !vw_en, "R12 idle outputs", busy, 0);
    check(len_out == 8'h00 && !blank_on, "R12 length and arming", len_out, 0);

    // R1 length sweep, general mode, both speeds
    begin
      int lens[6] = '{0, 1, 2, 5, 31, 127};
      for (int i = 0; i < 6; i++) begin
        prog('h0100 + i * 'h731, 'h0040 + i * 'h2E5, lens[i], 0);
        chunk(1, i % 2, 0, "sweep");
      end
    end
    // R3 window fold across the 0x1FFF boundary
    prog('h1230, 'h3FF8, 1, 0);
    chunk(1, 0, 0, "fold");
    // R10 continue without reprogramming
    cfgw(2, 'h02); m_len = 'h02;
    chunk(1, 1, 0, "continue R10");
    // R4 into and out of the unreadable regions, plus source wrap
    prog('h7FF0, 'h0000, 2, 0);  chunk(1, 0, 0, "video src");
    prog('h9FF0, 'h0100, 1, 0);  chunk(1, 0, 0, "video exit");
    prog('hFDE0, 'h0200, 3, 0);  chunk(1, 1, 0, "top src");
    prog('hFFF0, 'h0300, 1, 0);  chunk(1, 0, 0, "src wrap");
    // R5 overflow cut, short and exact
    prog('h0400, 'hFFE0, 3, 0);  chunk(1, 0, 0, "ovf cut R5");
    prog('h0500, 'hFFF0, 0, 0);  chunk(1, 1, 0, "ovf exact R5");
    // R6 display disabled
    prog('h0600, 'h1000, 4, 0);  chunk(0, 0, 0, "disp off R6");
    // R11 requests while busy are ignored
    prog('h0700, 'h1100, 7, 0);  chunk(1, 0, 1, "poke R11");
    // R2 blanking mode: gen ignored while armed, three blocks, then disarmed
    prog('h2000, 'h0800, 2, 1);
    expect_ignored(1, "R2 general request while armed");
    chunk(1, 0, 1, "blank 1 R2");
    chunk(1, 1, 0, "blank 2 R10");
    chunk(1, 0, 0, "blank 3 R9");
    expect_ignored(0, "R2 blank request while disarmed");
    // R6 and R9: display off ends blanking after one block
    prog('h3000, 'h0900, 5, 1);  chunk(0, 0, 0, "blank disp off R6");
    expect_ignored(0, "R9 blank request after display-off end");
    // R5 and R9: overflow inside blanking mode
    prog('h4000, 'hFFF8, 3, 1);  chunk(1, 0, 0, "blank ovf R5");
    expect_ignored(0, "R9 blank request after overflow");
    summary();
  end
endmodule